// File: doc/BRIEF.md
# Two-Clock True Dual-Port Word Memory

This block is a word-organised RAM with two fully independent access ports, left and right. Each port has its own clock. Both ports may reach any word, including the same word in the same cycle. Every dynamic input of a port is captured on that port's rising clock edge before it acts. The word is cut into byte lanes with separate enables. Two chip enables of opposite polarity let several instances share one address space without an outside decoder.

Each port picks its read latency with a static mode pin.

- **Flow-through:** the word appears one cycle after the command is registered.
- **Pipelined:** an extra output register adds one more cycle, and the output stays valid one extra cycle after a deselect.

A per-port sleep pin freezes the port: its registers and the memory keep their state.

Read data leaves each port as a stream with a valid flag and no ready. The memory cannot stall, so there is no back-pressure. A consumer must take each word in the cycle its valid flag is high. Between valid beats the data bus holds its last value.

Top module: `tdp_ram`

## Requirements
- R1: In flow-through mode (mode pin 0), a selected read with output enable high is sampled at edge k. Its word and a high valid appear after edge k+1, and valid is still low after edge k.
- R2: In pipelined mode (mode pin 1), the same read appears after edge k+2, and valid is still low after edge k+1.
- R3: Lane 0 is bits 8:0 and is enabled by byte-enable bit 0. Lane 1 is bits 17:9 and is enabled by byte-enable bit 1. A write changes only the enabled lanes.
- R4: A read returns zero in every lane whose byte enable was low.
- R5: A port is selected only when its active-low enable is 0 and its active-high enable is 1. An unselected write leaves memory unchanged, and an unselected read gives no valid beat.
- R6: A read sampled with output enable low gives no valid beat.
- R7: After a deselect is sampled at edge k, valid stays high through edge k and falls after edge k+1 in flow-through mode. In pipelined mode it stays high through edge k+1 and falls after edge k+2.
- R8: While sleep is high at an edge, that port ignores its address, data, write, byte-enable, enable and output-enable inputs. It writes nothing, and its read data and valid hold their values.
- R9: Both ports share one memory. When one port writes a word at the same edge the other port reads it, the read returns the old contents, and a later read returns the new contents.
- R10: A read registered on the edge after a write to the same address on the same port returns the newly written data.
- R11: Active-low asynchronous reset clears both ports' read data and valid flags but leaves the memory contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both ports |
| clk_l | input | 1 | Left port clock |
| addr_l | input | ADDR_W | Left word address |
| wdata_l | input | LANES*LANE_W | Left write data |
| we_l | input | 1 | Left write (1) or read (0) |
| be_l | input | LANES | Left byte-lane enables, active high |
| en_n_l | input | 1 | Left chip enable, active low |
| en_l | input | 1 | Left chip enable, active high |
| oe_l | input | 1 | Left output enable |
| pipe_l | input | 1 | Left static latency select: 0 flow-through, 1 pipelined |
| sleep_l | input | 1 | Left freeze |
| rdata_l | output | LANES*LANE_W | Left read data |
| rvalid_l | output | 1 | Left read data valid |
| clk_r | input | 1 | Right port clock |
| addr_r | input | ADDR_W | Right word address |
| wdata_r | input | LANES*LANE_W | Right write data |
| we_r | input | 1 | Right write (1) or read (0) |
| be_r | input | LANES | Right byte-lane enables, active high |
| en_n_r | input | 1 | Right chip enable, active low |
| en_r | input | 1 | Right chip enable, active high |
| oe_r | input | 1 | Right output enable |
| pipe_r | input | 1 | Right static latency select: 0 flow-through, 1 pipelined |
| sleep_r | input | 1 | Right freeze |
| rdata_r | output | LANES*LANE_W | Right read data |
| rvalid_r | output | 1 | Right read data valid |

## Verification
The assertions assume the following about the inputs:

- The mode pin of a port does not change while that port sleeps or has a read in flight.
- Reset is low before the first clock edge.
- The two ports never write the same word at the same edge, since that word's value is undefined.

The stimulus changes a mode pin only after its port has been deselected for several cycles. It holds reset from time zero, and it gives each port its own words, except in the write-against-read test where one port only reads.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  typedef enum logic {
    LAT_FLOW = 1'b0,
    LAT_PIPE = 1'b1
  } lat_mode_e;
endpackage

// File: rtl/tdp_core.sv
module tdp_core #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk_a,
  input  logic [ADDR_W-1:0]         addr_a,
  input  logic [LANES*LANE_W-1:0]   wdata_a,
  input  logic [LANES-1:0]          wlane_a,
  output logic [LANES*LANE_W-1:0]   rword_a,
  input  logic                      clk_b,
  input  logic [ADDR_W-1:0]         addr_b,
  input  logic [LANES*LANE_W-1:0]   wdata_b,
  input  logic [LANES-1:0]          wlane_b,
  output logic [LANES*LANE_W-1:0]   rword_b
);
  localparam int DEPTH = 1 << ADDR_W;

  // Each port owns one bank; a word is the XOR of both banks, so no bank
  // has two writers even though both ports write the whole address space.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank_a [DEPTH];
    logic [LANE_W-1:0] bank_b [DEPTH];

    always_ff @(posedge clk_a) begin
      if (wlane_a[g])
        bank_a[addr_a] <= wdata_a[g*LANE_W +: LANE_W] ^ bank_b[addr_a];
    end

    always_ff @(posedge clk_b) begin
      if (wlane_b[g])
        bank_b[addr_b] <= wdata_b[g*LANE_W +: LANE_W] ^ bank_a[addr_b];
    end

    assign rword_a[g*LANE_W +: LANE_W] = bank_a[addr_a] ^ bank_b[addr_a];
    assign rword_b[g*LANE_W +: LANE_W] = bank_a[addr_b] ^ bank_b[addr_b];
  end
endmodule

// File: rtl/tdp_port.sv
module tdp_port
  import tdp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      we,
  input  logic [LANES-1:0]          be,
  input  logic                      en_n,
  input  logic                      en,
  input  logic                      oe,
  input  logic                      pipe,
  input  logic                      sleep,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [LANES*LANE_W-1:0]   mem_wdata,
  output logic [LANES-1:0]          mem_wlane,
  input  logic [LANES*LANE_W-1:0]   mem_rword,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rvalid
);
  localparam int W = LANES * LANE_W;

  logic              sel_in;
  logic [ADDR_W-1:0] addr_q;
  logic [W-1:0]      wdata_q;
  logic [LANES-1:0]  be_q;
  logic              we_q, oe_q, sel_q;
  logic [W-1:0]      lane_mask;
  logic [W-1:0]      f_data, p_data;
  logic              f_valid, p_valid;
  lat_mode_e         mode;

  assign sel_in = !en_n && en;
  assign mode   = lat_mode_e'(pipe);

  // Command capture stage; frozen while asleep.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      we_q    <= 1'b0;
      oe_q    <= 1'b0;
      sel_q   <= 1'b0;
    end else if (!sleep) begin
      addr_q  <= addr;
      wdata_q <= wdata;
      be_q    <= be;
      we_q    <= we;
      oe_q    <= oe;
      sel_q   <= sel_in;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{be_q[g]}};
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_wlane = (sel_q && we_q && !sleep) ? be_q : '0;

  // Flow-through register, then the extra pipelined register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_data  <= '0;
      f_valid <= 1'b0;
      p_data  <= '0;
      p_valid <= 1'b0;
    end else if (!sleep) begin
      f_valid <= sel_q && oe_q && !we_q;
      if (sel_q && !we_q) f_data <= mem_rword & lane_mask;
      p_valid <= f_valid;
      p_data  <= f_data;
    end
  end

  assign rdata  = (mode == LAT_PIPE) ? p_data  : f_data;
  assign rvalid = (mode == LAT_PIPE) ? p_valid : f_valid;

  // Count of consecutive awake edges since reset, saturating at 3.
  logic [1:0] awake_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              awake_cnt <= '0;
    else if (sleep)          awake_cnt <= '0;
    else if (awake_cnt != 2'd3) awake_cnt <= awake_cnt + 2'd1;
  end

  a_r5_unselected_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (awake_cnt >= 2'd2 && !pipe && !$past(sel_in, 2)) |-> !rvalid);

  a_r6_oe_low_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (awake_cnt >= 2'd2 && !pipe && !$past(oe, 2)) |-> !rvalid);

  a_r7_pipe_deselect_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (awake_cnt == 2'd3 && pipe && !$past(sel_in, 3)) |-> !rvalid);

  a_r8_sleep_holds_output: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(rvalid) && $stable(rdata)));

  a_r11_reset_clears_valid: assert property (@(posedge clk)
    !rst_n |-> (!rvalid && rdata == '0));
endmodule

// File: rtl/tdp_ram.sv
module tdp_ram #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      rst_n,
  input  logic                      clk_l,
  input  logic [ADDR_W-1:0]         addr_l,
  input  logic [LANES*LANE_W-1:0]   wdata_l,
  input  logic                      we_l,
  input  logic [LANES-1:0]          be_l,
  input  logic                      en_n_l,
  input  logic                      en_l,
  input  logic                      oe_l,
  input  logic                      pipe_l,
  input  logic                      sleep_l,
  output logic [LANES*LANE_W-1:0]   rdata_l,
  output logic                      rvalid_l,
  input  logic                      clk_r,
  input  logic [ADDR_W-1:0]         addr_r,
  input  logic [LANES*LANE_W-1:0]   wdata_r,
  input  logic                      we_r,
  input  logic [LANES-1:0]          be_r,
  input  logic                      en_n_r,
  input  logic                      en_r,
  input  logic                      oe_r,
  input  logic                      pipe_r,
  input  logic                      sleep_r,
  output logic [LANES*LANE_W-1:0]   rdata_r,
  output logic                      rvalid_r
);
  localparam int W = LANES * LANE_W;

  logic [ADDR_W-1:0] m_addr_l, m_addr_r;
  logic [W-1:0]      m_wdata_l, m_wdata_r, m_rword_l, m_rword_r;
  logic [LANES-1:0]  m_wlane_l, m_wlane_r;

  tdp_port #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_port_l (
    .clk(clk_l), .rst_n(rst_n), .addr(addr_l), .wdata(wdata_l), .we(we_l),
    .be(be_l), .en_n(en_n_l), .en(en_l), .oe(oe_l), .pipe(pipe_l),
    .sleep(sleep_l), .mem_addr(m_addr_l), .mem_wdata(m_wdata_l),
    .mem_wlane(m_wlane_l), .mem_rword(m_rword_l), .rdata(rdata_l),
    .rvalid(rvalid_l)
  );

  tdp_port #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_port_r (
    .clk(clk_r), .rst_n(rst_n), .addr(addr_r), .wdata(wdata_r), .we(we_r),
    .be(be_r), .en_n(en_n_r), .en(en_r), .oe(oe_r), .pipe(pipe_r),
    .sleep(sleep_r), .mem_addr(m_addr_r), .mem_wdata(m_wdata_r),
    .mem_wlane(m_wlane_r), .mem_rword(m_rword_r), .rdata(rdata_r),
    .rvalid(rvalid_r)
  );

  tdp_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_core (
    .clk_a(clk_l), .addr_a(m_addr_l), .wdata_a(m_wdata_l), .wlane_a(m_wlane_l),
    .rword_a(m_rword_l),
    .clk_b(clk_r), .addr_b(m_addr_r), .wdata_b(m_wdata_r), .wlane_b(m_wlane_r),
    .rword_b(m_rword_r)
  );
endmodule

// File: tb/sim_tdp_ram.sv
`timescale 1ns/1ps
module sim_tdp_ram;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [3:0]  addr_l, addr_r;
  logic [17:0] wdata_l, wdata_r, rdata_l, rdata_r;
  logic        we_l, we_r, en_n_l, en_n_r, en_l, en_r, oe_l, oe_r;
  logic        pipe_l, pipe_r, sleep_l, sleep_r, rvalid_l, rvalid_r;
  logic [1:0]  be_l, be_r;

  int checks = 0;
  int errors = 0;

  tdp_ram u0 (
    .rst_n(rst_n),
    .clk_l(clk), .addr_l(addr_l), .wdata_l(wdata_l), .we_l(we_l), .be_l(be_l),
    .en_n_l(en_n_l), .en_l(en_l), .oe_l(oe_l), .pipe_l(pipe_l), .sleep_l(sleep_l),
    .rdata_l(rdata_l), .rvalid_l(rvalid_l),
    .clk_r(clk), .addr_r(addr_r), .wdata_r(wdata_r), .we_r(we_r), .be_r(be_r),
    .en_n_r(en_n_r), .en_r(en_r), .oe_r(oe_r), .pipe_r(pipe_r), .sleep_r(sleep_r),
    .rdata_r(rdata_r), .rvalid_r(rvalid_r)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  be;
    logic [3:0]  addr;
    logic [17:0] data;   // write data, or expected read data
  } vec_t;

  localparam vec_t VT [0:7] = '{
    '{1'b1, 2'b11, 4'd3, 18'h12345},
    '{1'b1, 2'b11, 4'd5, 18'h3FFFF},
    '{1'b1, 2'b01, 4'd3, 18'h00FFF},
    '{1'b0, 2'b11, 4'd3, 18'h123FF},
    '{1'b0, 2'b10, 4'd5, 18'h3FE00},
    '{1'b0, 2'b01, 4'd3, 18'h001FF},
    '{1'b1, 2'b10, 4'd5, 18'h00000},
    '{1'b0, 2'b11, 4'd5, 18'h001FF}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input bit right, input logic sel, input logic we,
                     input logic [1:0] be, input logic [3:0] a, input logic [17:0] d);
    if (!right) begin
      en_n_l = !sel; en_l = sel; we_l = we; be_l = be; addr_l = a; wdata_l = d;
    end else begin
      en_n_r = !sel; en_r = sel; we_r = we; be_r = be; addr_r = a; wdata_r = d;
    end
  endtask

  task automatic idle(input bit right);
    cmd(right, 1'b0, 1'b0, 2'b00, 4'd0, 18'h0);
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    oe_l = 1'b1; oe_r = 1'b1; pipe_l = 1'b0; pipe_r = 1'b0;
    sleep_l = 1'b0; sleep_r = 1'b0;
    idle(0); idle(1);
    tick(); tick();
    chk("R11 reset left", {rvalid_l, rdata_l}, 19'h0);
    chk("R11 reset right", {rvalid_r, rdata_r}, 19'h0);
    rst_n = 1'b1;
    tick();

    // R3 R4: table walk on the left port, flow-through
    for (int i = 0; i < 8; i++) begin
      cmd(0, 1'b1, VT[i].we, VT[i].be, VT[i].addr, VT[i].we ? VT[i].data : 18'h0);
      tick();
      idle(0);
      tick();
      if (!VT[i].we) chk($sformatf("R3/R4 vector %0d", i), {rvalid_l, rdata_l}, {1'b1, VT[i].data});
    end

    // R1 flow-through latency
    cmd(0, 1'b1, 1'b0, 2'b11, 4'd3, 18'h0);
    tick();
    chk("R1 not early", {1'b0, rvalid_l}, 19'h0);
    idle(0);
    tick();
    chk("R1 flow data", {rvalid_l, rdata_l}, {1'b1, 18'h123FF});

    // R2 pipelined latency on the right, also reads the left's writes (R9)
    pipe_r = 1'b1;
    tick();
    cmd(1, 1'b1, 1'b0, 2'b11, 4'd3, 18'h0);
    tick();
    idle(1);
    tick();
    chk("R2 not early", {1'b0, rvalid_r}, 19'h0);
    tick();
    chk("R2 pipe data", {rvalid_r, rdata_r}, {1'b1, 18'h123FF});

    // R7 dual-cycle deselect in pipelined mode
    cmd(1, 1'b1, 1'b0, 2'b11, 4'd5, 18'h0);
    tick(); tick(); tick();
    chk("R7 pipe streaming", {rvalid_r, rdata_r}, {1'b1, 18'h001FF});
    idle(1);
    tick();
    chk("R7 pipe deselect +1", {1'b0, rvalid_r}, 19'h1);
    tick();
    chk("R7 pipe deselect +2", {1'b0, rvalid_r}, 19'h1);
    tick();
    chk("R7 pipe deselect +3", {1'b0, rvalid_r}, 19'h0);

    // R7 flow-through deselect
    cmd(0, 1'b1, 1'b0, 2'b11, 4'd5, 18'h0);
    tick(); tick();
    idle(0);
    tick();
    chk("R7 flow deselect +1", {1'b0, rvalid_l}, 19'h1);
    tick();
    chk("R7 flow deselect +2", {1'b0, rvalid_l}, 19'h0);

    // R6 output enable low
    oe_l = 1'b0;
    cmd(0, 1'b1, 1'b0, 2'b11, 4'd3, 18'h0);
    tick();
    idle(0);
    oe_l = 1'b1;
    tick();
    chk("R6 oe low", {1'b0, rvalid_l}, 19'h0);

    // R5 half-selected writes are dropped
    cmd(0, 1'b1, 1'b1, 2'b11, 4'd3, 18'h0);
    en_n_l = 1'b1; en_l = 1'b1;
    tick();
    en_n_l = 1'b0; en_l = 1'b0;
    tick();
    idle(0);
    tick();
    cmd(0, 1'b1, 1'b0, 2'b11, 4'd3, 18'h0);
    tick();
    idle(0);
    tick();
    chk("R5 unselected write ignored", {rvalid_l, rdata_l}, {1'b1, 18'h123FF});

    // R10 read right after write on the same port
    cmd(0, 1'b1, 1'b1, 2'b11, 4'd9, 18'h0ABCD);
    tick();
    cmd(0, 1'b1, 1'b0, 2'b11, 4'd9, 18'h0);
    tick();
    idle(0);
    tick();
    chk("R10 read after write", {rvalid_l, rdata_l}, {1'b1, 18'h0ABCD});

    // R9 write on one port against read on the other at the same edge
    pipe_r = 1'b0;
    cmd(0, 1'b1, 1'b1, 2'b11, 4'd7, 18'h2AAAA);
    tick();
    idle(0);
    tick();
    cmd(0, 1'b1, 1'b1, 2'b11, 4'd7, 18'h15555);
    cmd(1, 1'b1, 1'b0, 2'b11, 4'd7, 18'h0);
    tick();
    idle(0); idle(1);
    tick();
    chk("R9 same-edge read sees old", {rvalid_r, rdata_r}, {1'b1, 18'h2AAAA});
    cmd(1, 1'b1, 1'b0, 2'b11, 4'd7, 18'h0);
    tick();
    idle(1);
    tick();
    chk("R9 later read sees new", {rvalid_r, rdata_r}, {1'b1, 18'h15555});

    // R8 sleep freezes the left port
    cmd(0, 1'b1, 1'b0, 2'b11, 4'd3, 18'h0);
    tick(); tick();
    sleep_l = 1'b1;
    cmd(0, 1'b1, 1'b1, 2'b11, 4'd3, 18'h0);
    tick(); tick(); tick();
    chk("R8 output held", {rvalid_l, rdata_l}, {1'b1, 18'h123FF});
    idle(0);
    sleep_l = 1'b0;
    tick();
    cmd(0, 1'b1, 1'b0, 2'b11, 4'd3, 18'h0);
    tick();
    idle(0);
    tick();
    chk("R8 write during sleep ignored", {rvalid_l, rdata_l}, {1'b1, 18'h123FF});

    // R11 reset keeps memory
    rst_n = 1'b0;
    tick();
    chk("R11 reset clears output", {rvalid_l, rdata_l}, 19'h0);
    rst_n = 1'b1;
    tick();
    cmd(0, 1'b1, 1'b0, 2'b11, 4'd9, 18'h0);
    tick();
    idle(0);
    tick();
    chk("R11 memory kept", {rvalid_l, rdata_l}, {1'b1, 18'h0ABCD});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule